// File: doc/BRIEF.md
# Selective Victim Cache Controller

This block holds the tag, data and control state of a direct-mapped first-level cache backed by a small fully associative victim buffer. A line pushed out of the main array is kept in the victim buffer, so that a later access can still find it without going to the next memory level. A victim hit does not always swap lines. The line is first copied into a single transitory line. One prediction bit per line then decides between two outcomes. The line may be exchanged with the conflicting main-array line. Otherwise it is served from the transitory line while the main-array line stays where it is.

Requests arrive one line address at a time. Each accepted request produces exactly one registered response, tagged with the place the data came from. A request that misses everywhere raises a fill request toward the next level. It waits for the fill data, installs the line in the main array and moves the displaced line into the victim buffer. A mode flag shows whether the controller is in its special mode, where repeated accesses go to the transitory line. Two counters report exchanges performed and exchanges avoided.

Top module: `sel_victim_cache`

## Requirements
- R1: After synchronous reset, req_ready is 1. special_mode, resp_valid and fill_req are 0, and both counters are 0.
- R2: An accepted request whose line is valid in the main array with a matching tag gives resp_valid one cycle later, with that line's data and resp_src = 0 (main array).
- R3: A request that hits neither the main array, nor the victim buffer, nor the transitory line raises fill_req, with fill_addr equal to the request address, from the next cycle on. While fill_req is high, req_ready is low. The cycle after fill_valid is seen, the response carries fill_data with resp_src = 3 (fill), and the line becomes resident in the main array.
- R4: A valid main-array line displaced by a fill or by an exchange is written into the victim buffer, so a later access to it is a victim hit.
- R5: On a victim hit where the main line's prediction bit is clear, or the victim line's bit is set, the lines are exchanged. The response has resp_src = 2 (exchange), swap_cnt increases by exactly one, and the old main line goes into the victim buffer.
- R6: On a victim hit where the main line's prediction bit is set and the victim line's bit is clear, no exchange happens. The response has resp_src = 1 (transitory), keep_cnt increases by one and special_mode rises. The main-array line stays resident.
- R7: In special mode, a repeated access to the transitory line's address is served with resp_src = 1, and neither counter changes.
- R8: Special mode ends when an access to the transitory line's index targets a different tag, whether that access hits in the main array, causes an exchange or causes a fill. Accesses to other indices leave the mode unchanged.
- R9: A line's prediction bit is set when it is hit: in the main array, in the victim buffer or through the transitory line. The main line's bit is cleared when a main-array miss at its index goes through the victim buffer or the fill path. A newly filled line starts with its bit clear.
- R10: The victim buffer holds VICT_N lines and fills empty entries first. When it is full, it evicts the least recently used entry. A victim hit or an insertion makes that entry most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Line address; the low IDX_W bits select the main-array index |
| req_ready | output | 1 | Controller can accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Data of the accessed line |
| resp_src | output | 2 | 0 main, 1 transitory, 2 exchange, 3 fill |
| fill_req | output | 1 | Line requested from the next level |
| fill_addr | output | ADDR_W | Address of the requested line |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DATA_W | Line data from the next level |
| special_mode | output | 1 | Accesses are being routed to the transitory line |
| swap_cnt | output | CNT_W | Exchanges performed |
| keep_cnt | output | CNT_W | Exchanges avoided |

## Verification
On every cycle, the assertions check the following:
- req_ready stays low while a fill is outstanding.
- A fill always yields a response tagged as a fill.
- Each counter moves by at most one, and only together with a response of the matching kind.
- Special mode is only entered together with a transitory response.
- No response appears without an accepted request or a fill beat.

Some behaviour needs a history of accesses, and only the directed scenarios can show it:
- the prediction bits steering the exchange decision;
- eviction in least-recently-used order;
- leaving special mode on a conflicting tag but not on other indices;
- the main-array line surviving a declined exchange.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN  = 2'd0,
    SRC_TRANS = 2'd1,
    SRC_SWAP  = 2'd2,
    SRC_FILL  = 2'd3
  } src_e;

  typedef enum logic {
    PH_LOOKUP = 1'b0,
    PH_FILL   = 1'b1
  } phase_e;
endpackage

// File: rtl/svc_main_arr.sv
module svc_main_arr #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pred,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pred,
  input  logic              pu_en,
  input  logic [IDX_W-1:0]  pu_idx,
  input  logic              pu_val
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  pred_q;

  // storage arrays: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      pred_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx]  <= 1'b1;
      pred_q[wr_idx] <= wr_pred;
    end else if (pu_en) begin
      pred_q[pu_idx] <= pu_val;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];
  assign rd_pred = pred_q[rd_idx];
endmodule

// File: rtl/svc_vict_buf.sv
module svc_vict_buf #(
  parameter int LA_W   = 12,
  parameter int DATA_W = 16,
  parameter int N      = 8,
  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LA_W-1:0]   lk_addr,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_pred,
  output logic [SLOT_W-1:0] repl_slot,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_vld,
  input  logic [LA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pred,
  input  logic              pu_en,
  input  logic [SLOT_W-1:0] pu_slot,
  input  logic              pu_val,
  input  logic              tch_en,
  input  logic [SLOT_W-1:0] tch_slot
);
  logic [LA_W-1:0]   addr_q [N];
  logic [DATA_W-1:0] data_q [N];
  logic [SLOT_W-1:0] age_q  [N];
  logic [N-1:0]      vld_q;
  logic [N-1:0]      pred_q;
  logic [N-1:0]      match;
  logic              have_free;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (addr_q[g] == lk_addr);
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (!lk_hit && match[i]) begin
        lk_hit  = 1'b1;
        lk_slot = SLOT_W'(i);
      end
    end
  end

  assign lk_data = data_q[lk_slot];
  assign lk_pred = pred_q[lk_slot];

  // empty entry first, otherwise the oldest one
  always_comb begin
    have_free = 1'b0;
    repl_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (!have_free && !vld_q[i]) begin
        have_free = 1'b1;
        repl_slot = SLOT_W'(i);
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == SLOT_W'(N - 1)) repl_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_slot] <= wr_addr;
      data_q[wr_slot] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      pred_q <= '0;
    end else begin
      if (wr_en) begin
        vld_q[wr_slot]  <= wr_vld;
        pred_q[wr_slot] <= wr_pred;
      end
      if (pu_en) pred_q[pu_slot] <= pu_val;
    end
  end

  // ages form a permutation of 0..N-1; 0 is most recently used
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= SLOT_W'(i);
    end else if (tch_en) begin
      for (int i = 0; i < N; i++) begin
        if (SLOT_W'(i) == tch_slot) age_q[i] <= '0;
        else if (age_q[i] < age_q[tch_slot]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sel_victim_cache.sv
module sel_victim_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16,
  parameter int VICT_N = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_src,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              special_mode,
  output logic [CNT_W-1:0]  swap_cnt,
  output logic [CNT_W-1:0]  keep_cnt
);
  import svc_pkg::*;

  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = (VICT_N > 1) ? $clog2(VICT_N) : 1;

  phase_e            phase_q;
  logic [ADDR_W-1:0] pend_q;
  logic              special_q;
  logic [ADDR_W-1:0] tr_addr_q;
  logic [DATA_W-1:0] tr_data_q;
  logic              resp_vld_q;
  logic [DATA_W-1:0] resp_data_q;
  src_e              resp_src_q;
  logic              fill_req_q;
  logic [CNT_W-1:0]  swap_q, keep_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              m_vld, m_pred;
  logic [TAG_W-1:0]  m_tag;
  logic [DATA_W-1:0] m_data;
  logic              v_hit, v_pred;
  logic [SLOT_W-1:0] v_slot, v_repl;
  logic [DATA_W-1:0] v_data;

  logic              mwr_en, mwr_pred, mpu_en, mpu_val;
  logic [DATA_W-1:0] mwr_data;
  logic              vwr_en, vwr_vld, vwr_pred, vpu_en, vpu_val, tch_en;
  logic [SLOT_W-1:0] vwr_slot, vpu_slot, tch_slot;
  logic [ADDR_W-1:0] vwr_addr;
  logic [DATA_W-1:0] vwr_data;

  logic acc, fill_done, m_hit, t_hit, tr_same_idx, keep_line;

  assign acc         = req_valid && (phase_q == PH_LOOKUP);
  assign fill_done   = fill_valid && (phase_q == PH_FILL);
  assign cur_addr    = (phase_q == PH_FILL) ? pend_q : req_addr;
  assign idx         = cur_addr[IDX_W-1:0];
  assign tag         = cur_addr[ADDR_W-1:IDX_W];
  assign m_hit       = m_vld && (m_tag == tag);
  assign t_hit       = special_q && (tr_addr_q == req_addr);
  assign tr_same_idx = special_q && (tr_addr_q[IDX_W-1:0] == idx);
  assign keep_line   = m_vld && m_pred && !v_pred;

  svc_main_arr #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_main (
    .clk(clk), .rst(rst),
    .rd_idx(idx), .rd_vld(m_vld), .rd_tag(m_tag), .rd_data(m_data), .rd_pred(m_pred),
    .wr_en(mwr_en), .wr_idx(idx), .wr_tag(tag), .wr_data(mwr_data), .wr_pred(mwr_pred),
    .pu_en(mpu_en), .pu_idx(idx), .pu_val(mpu_val)
  );

  svc_vict_buf #(.LA_W(ADDR_W), .DATA_W(DATA_W), .N(VICT_N)) u_vict (
    .clk(clk), .rst(rst),
    .lk_addr(req_addr), .lk_hit(v_hit), .lk_slot(v_slot), .lk_data(v_data), .lk_pred(v_pred),
    .repl_slot(v_repl),
    .wr_en(vwr_en), .wr_slot(vwr_slot), .wr_vld(vwr_vld), .wr_addr(vwr_addr),
    .wr_data(vwr_data), .wr_pred(vwr_pred),
    .pu_en(vpu_en), .pu_slot(vpu_slot), .pu_val(vpu_val),
    .tch_en(tch_en), .tch_slot(tch_slot)
  );

  // storage update decisions
  always_comb begin
    mwr_en = 1'b0; mwr_data = '0; mwr_pred = 1'b0;
    mpu_en = 1'b0; mpu_val = 1'b0;
    vwr_en = 1'b0; vwr_slot = '0; vwr_vld = 1'b0; vwr_addr = '0; vwr_data = '0; vwr_pred = 1'b0;
    vpu_en = 1'b0; vpu_slot = '0; vpu_val = 1'b0;
    tch_en = 1'b0; tch_slot = '0;
    if (acc) begin
      if (t_hit) begin
        vpu_en = v_hit; vpu_slot = v_slot; vpu_val = 1'b1;
        tch_en = v_hit; tch_slot = v_slot;
      end else if (m_hit) begin
        mpu_en = 1'b1; mpu_val = 1'b1;
      end else if (v_hit) begin
        tch_en = 1'b1; tch_slot = v_slot;
        if (keep_line) begin
          mpu_en = 1'b1; mpu_val = 1'b0;
          vpu_en = 1'b1; vpu_slot = v_slot; vpu_val = 1'b1;
        end else begin
          mwr_en = 1'b1; mwr_data = v_data; mwr_pred = 1'b1;
          vwr_en = 1'b1; vwr_slot = v_slot; vwr_vld = m_vld;
          vwr_addr = {m_tag, idx}; vwr_data = m_data; vwr_pred = 1'b0;
        end
      end
    end else if (fill_done) begin
      mwr_en = 1'b1; mwr_data = fill_data; mwr_pred = 1'b0;
      if (m_vld) begin
        vwr_en = 1'b1; vwr_slot = v_repl; vwr_vld = 1'b1;
        vwr_addr = {m_tag, idx}; vwr_data = m_data; vwr_pred = 1'b0;
        tch_en = 1'b1; tch_slot = v_repl;
      end
    end
  end

  // sequencer, transitory line, response and counters
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_LOOKUP;
      pend_q      <= '0;
      special_q   <= 1'b0;
      tr_addr_q   <= '0;
      tr_data_q   <= '0;
      resp_vld_q  <= 1'b0;
      resp_data_q <= '0;
      resp_src_q  <= SRC_MAIN;
      fill_req_q  <= 1'b0;
      swap_q      <= '0;
      keep_q      <= '0;
    end else begin
      resp_vld_q <= 1'b0;
      if (acc) begin
        if (t_hit) begin
          resp_vld_q <= 1'b1; resp_data_q <= tr_data_q; resp_src_q <= SRC_TRANS;
        end else if (m_hit) begin
          resp_vld_q <= 1'b1; resp_data_q <= m_data; resp_src_q <= SRC_MAIN;
          if (tr_same_idx) special_q <= 1'b0;
        end else if (v_hit) begin
          resp_vld_q  <= 1'b1;
          resp_data_q <= v_data;
          if (keep_line) begin
            resp_src_q <= SRC_TRANS;
            special_q  <= 1'b1;
            tr_addr_q  <= req_addr;
            tr_data_q  <= v_data;
            keep_q     <= keep_q + 1'b1;
          end else begin
            resp_src_q <= SRC_SWAP;
            swap_q     <= swap_q + 1'b1;
            if (tr_same_idx) special_q <= 1'b0;
          end
        end else begin
          phase_q    <= PH_FILL;
          pend_q     <= req_addr;
          fill_req_q <= 1'b1;
        end
      end else if (fill_done) begin
        phase_q     <= PH_LOOKUP;
        fill_req_q  <= 1'b0;
        resp_vld_q  <= 1'b1;
        resp_data_q <= fill_data;
        resp_src_q  <= SRC_FILL;
        if (tr_same_idx) special_q <= 1'b0;
      end
    end
  end

  assign req_ready    = (phase_q == PH_LOOKUP);
  assign resp_valid   = resp_vld_q;
  assign resp_data    = resp_data_q;
  assign resp_src     = resp_src_q;
  assign fill_req     = fill_req_q;
  assign fill_addr    = pend_q;
  assign special_mode = special_q;
  assign swap_cnt     = swap_q;
  assign keep_cnt     = keep_q;
endmodule

// File: rtl/svc_chk.sv
module svc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [1:0]       resp_src,
  input logic             fill_req,
  input logic             fill_valid,
  input logic             special_mode,
  input logic [CNT_W-1:0] swap_cnt,
  input logic [CNT_W-1:0] keep_cnt
);
  // R3
  fill_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !req_ready);

  // R3
  fill_gives_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_valid) |=> (resp_valid && resp_src == 2'd3));

  // R5
  swap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (swap_cnt != $past(swap_cnt)) |->
      (swap_cnt == $past(swap_cnt) + CNT_W'(1)) && resp_valid && resp_src == 2'd2);

  // R6
  keep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (keep_cnt != $past(keep_cnt)) |->
      (keep_cnt == $past(keep_cnt) + CNT_W'(1)) && resp_valid && resp_src == 2'd1 && special_mode);

  // R6
  special_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(special_mode) |-> (resp_valid && resp_src == 2'd1));

  // R2
  resp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid && req_ready) || $past(fill_req && fill_valid)));
endmodule

bind sel_victim_cache svc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_src(resp_src), .fill_req(fill_req),
  .fill_valid(fill_valid), .special_mode(special_mode),
  .swap_cnt(swap_cnt), .keep_cnt(keep_cnt)
);

// File: tb/sel_victim_cache_test.sv
module sel_victim_cache_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, resp_valid, fill_req, special_mode;
  logic [DATA_W-1:0] resp_data;
  logic [1:0]        resp_src;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic [CNT_W-1:0]  swap_cnt, keep_cnt;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  sel_victim_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .special_mode(special_mode),
    .swap_cnt(swap_cnt), .keep_cnt(keep_cnt)
  );

  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] line_val(input logic [ADDR_W-1:0] a);
    return {4'hC, a} ^ 16'h0A50;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input int exp_src, input string rq);
    int n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && n < 100) begin
      if (fill_req && !fill_valid) begin
        chk(fill_addr == a, "R3 fill_addr", int'(fill_addr), int'(a));
        chk(!req_ready, "R3 ready low during fill", int'(req_ready), 0);
        fill_valid = 1'b1;
        fill_data  = line_val(a);
      end else begin
        fill_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    fill_valid = 1'b0;
    chk(resp_valid, {rq, " resp_valid"}, int'(resp_valid), 1);
    chk(int'(resp_src) == exp_src, {rq, " resp_src"}, int'(resp_src), exp_src);
    chk(resp_data == line_val(a), {rq, " resp_data"}, int'(resp_data), int'(line_val(a)));
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(special_mode == 1'b0, "R1 special_mode", int'(special_mode), 0);
    chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
    chk(fill_req == 1'b0, "R1 fill_req", int'(fill_req), 0);
    chk(swap_cnt == 0 && keep_cnt == 0, "R1 counters", int'(swap_cnt) + int'(keep_cnt), 0);
  endtask

  task automatic t_fill_hit();
    access(12'h013, 3, "R3 cold miss");
    access(12'h013, 0, "R2 main hit");
  endtask

  task automatic t_exchange();
    access(12'h023, 3, "R4 conflicting fill");
    // R9: the miss cleared 0x023's neighbour bit, so victim hit on 0x013 exchanges
    access(12'h013, 2, "R5 exchange");
    chk(swap_cnt == 1, "R5 swap_cnt", int'(swap_cnt), 1);
    chk(keep_cnt == 0, "R5 keep_cnt", int'(keep_cnt), 0);
  endtask

  task automatic t_keep_special();
    access(12'h013, 0, "R2 hit after exchange");
    access(12'h023, 1, "R6 exchange declined");
    chk(keep_cnt == 1, "R6 keep_cnt", int'(keep_cnt), 1);
    chk(swap_cnt == 1, "R6 swap_cnt unchanged", int'(swap_cnt), 1);
    chk(special_mode, "R6 special entered", int'(special_mode), 1);
    access(12'h023, 1, "R7 transitory repeat");
    chk(keep_cnt == 1 && swap_cnt == 1, "R7 counters unchanged",
        int'(keep_cnt) + int'(swap_cnt), 2);
    access(12'h055, 3, "R8 other index fill");
    chk(special_mode, "R8 special kept on other index", int'(special_mode), 1);
    access(12'h013, 0, "R6 main line kept");
    chk(!special_mode, "R8 special left on main hit", int'(special_mode), 0);
    access(12'h023, 2, "R9 both bits set exchange");
    chk(swap_cnt == 2, "R9 swap_cnt", int'(swap_cnt), 2);
  endtask

  task automatic t_lru();
    for (int t = 1; t <= 10; t++) access({4'h0, 4'(t), 4'h7}, 3, "R4 fill chain");
    access(12'h027, 2, "R10 retained entry");
    chk(swap_cnt == 3, "R10 swap_cnt", int'(swap_cnt), 3);
    access(12'h037, 1, "R6 keep at index 7");
    chk(keep_cnt == 2 && special_mode, "R6 keep_cnt and mode", int'(keep_cnt), 2);
    access(12'h0C7, 3, "R8 fill at transitory index");
    chk(!special_mode, "R8 special left on fill", int'(special_mode), 0);
    access(12'h047, 3, "R10 oldest evicted");
    access(12'h0A7, 2, "R10 recent entry kept");
    access(12'h013, 3, "R10 early entry evicted");
    chk(swap_cnt == 4, "R10 final swap_cnt", int'(swap_cnt), 4);
    chk(keep_cnt == 2, "R10 final keep_cnt", int'(keep_cnt), 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_exchange();
    t_keep_special();
    t_lru();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule